// File: doc/BRIEF.md
# SPI Serial-Memory Boot Loader

After reset this engine copies a fixed-size boot image from an external serial EEPROM into on-chip instruction RAM and then hands the processor its entry point. A single start pulse makes it open one SPI read transaction in mode 0. It sends the read opcode and then a constant four-byte zero address, and clocks in a fixed number of image bytes. Each byte goes through a plain synchronous write port to consecutive RAM addresses, starting at the load base.

The address phase is always four bytes long, whatever the attached memory uses. A memory with a narrower address starts returning data while the loader is still sending address bytes. The loader discards everything received before the data phase, so the image must be stored with a leading pad that matches the memory's address width. When the last byte is written, chip select is released. After at least one SCK period of idle time the engine raises `boot_done` and pulses `cpu_run`, with `cpu_start_addr` pointing at the load base. The engine loads once per reset.

Top module: `spi_boot_loader`

## Requirements
- R1: While reset is held (synchronous, active low), `spi_cs_n` is 1, `spi_sck` is 0, `ram_we` is 0, `boot_done` is 0 and `cpu_run` is 0.
- R2: The first 8 bits of the transaction carry the opcode 0x03, most significant bit first. MOSI is valid at each SCK rising edge (mode 0), and SCK is 0 whenever `spi_cs_n` is 1.
- R3: Bits 8 to 39 (32 bits, four address bytes) are all 0 on MOSI. MISO is ignored during bits 0 to 39, so no RAM write can come from them.
- R4: From bit 40 on, exactly 512 bytes are captured from MISO at SCK rising edges, each assembled most significant bit first.
- R5: Each captured byte produces one single-cycle `ram_we` pulse. The write addresses are 0x100, 0x101, … in capture order, with the address advancing by one after each write.
- R6: `spi_cs_n` falls once per load and stays low from the first opcode bit to the last data bit, covering exactly 4136 SCK rising edges.
- R7: SCK rising edges are spaced 2*HALF_PERIOD system clocks apart.
- R8: `boot_done` rises no earlier than 2*HALF_PERIOD clocks after `spi_cs_n` rises. `cpu_run` is a one-cycle pulse in the cycle `boot_done` rises, and `cpu_start_addr` is 0x100.
- R9: A start pulse during a load is ignored: the transaction is not restarted or lengthened.
- R10: After `boot_done`, further start pulses are ignored until reset: `spi_cs_n` stays 1 and no RAM write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin the load (sampled when idle) |
| spi_cs_n | output | 1 | Serial memory chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |
| ram_addr | output | RAM_AW | Instruction RAM byte address |
| ram_wdata | output | 8 | Instruction RAM write data |
| ram_we | output | 1 | Instruction RAM write strobe |
| boot_done | output | 1 | Load complete (held until reset) |
| cpu_run | output | 1 | One-cycle release pulse to the processor |
| cpu_start_addr | output | RAM_AW | Execution entry address |

## Verification
The bench models a serial memory with each of the four address widths (4, 3, 2 and 1 bytes) in turn. The 1-byte memory wraps at 256 bytes. Each width shifts the point where real data starts on MISO relative to bit 40, so a wrong header length, a wrong capture start or an early sample lands on the wrong byte. Bits sent during the header are filled with junk, which separates a loader that ignores them from one that captures them. One run adds a start pulse in the middle of the load, and one adds a start pulse after completion, to show that both are ignored.

// File: rtl/spi_boot_pkg.sv
// Shared definitions for the SPI boot loader.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package spi_boot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_SETUP,  // chip select low, first MOSI bit settling
        ST_XFER,   // clocking opcode, address and image bits
        ST_GAP,    // chip select released, idle SCK period
        ST_DONE    // load finished, waits for reset
    } boot_state_t;

endpackage

// File: rtl/sbl_tick_gen.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF_PERIOD system clocks while run is high;
// the count restarts from zero whenever run is low.
// Assumes: HALF_PERIOD >= 1.
module sbl_tick_gen #(
    parameter int HALF_PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_PERIOD + 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_PERIOD - 1));

    // Count system clocks within one SCK half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sbl_rx_assembler.sv
// Byte assembler and RAM write port driver.
// Shifts one MISO bit in per sample pulse (MSB first). After every eighth
// bit it presents the byte with a one-cycle write strobe, then advances the
// RAM address by one.
// Assumes: sample pulses are at least two clocks apart and arrive in whole
// bytes since reset.
module sbl_rx_assembler #(
    parameter int                RAM_AW    = 10,
    parameter logic [RAM_AW-1:0] LOAD_BASE = RAM_AW'(16'h0100)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              bit_in,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_we
);
    logic [6:0] shreg;
    logic [2:0] bit_cnt;

    // Collect bits and issue a write strobe for each finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            ram_wdata <= '0;
            ram_we    <= 1'b0;
        end else begin
            ram_we <= 1'b0;
            if (sample) begin
                shreg   <= {shreg[5:0], bit_in};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    ram_wdata <= {shreg, bit_in};
                    ram_we    <= 1'b1;
                end
            end
        end
    end

    // Advance the write address once the current byte has been written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr <= LOAD_BASE;
        end else if (ram_we) begin
            ram_addr <= ram_addr + 1'b1;
        end
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (ram_addr == $past(ram_addr) + 1'b1)); // R5

endmodule

// File: rtl/spi_boot_loader.sv
// SPI serial-memory boot loader (top).
// On start, runs one mode-0 SPI read: the opcode, ADDR_BYTES zero address
// bytes, then IMAGE_BYTES data bytes written to RAM from LOAD_BASE up. It
// then releases chip select, waits one SCK period and signals completion
// with a cpu_run pulse. It loads once per reset.
// Assumes: HALF_PERIOD >= 1; RAM_AW covers LOAD_BASE + IMAGE_BYTES.
module spi_boot_loader
    import spi_boot_pkg::*;
#(
    parameter int                HALF_PERIOD = 2,
    parameter int                ADDR_BYTES  = 4,
    parameter int                IMAGE_BYTES = 512,
    parameter int                RAM_AW      = 10,
    parameter logic [RAM_AW-1:0] LOAD_BASE   = RAM_AW'(16'h0100),
    parameter logic [7:0]        READ_OP     = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_we,
    output logic              boot_done,
    output logic              cpu_run,
    output logic [RAM_AW-1:0] cpu_start_addr
);
    localparam int HDR_BITS   = 8 + 8 * ADDR_BYTES;
    localparam int TOTAL_BITS = HDR_BITS + 8 * IMAGE_BYTES;
    localparam int BW         = $clog2(TOTAL_BITS + 1);

    boot_state_t   state;
    logic [BW-1:0] bit_idx;
    logic          gap_cnt;
    logic          tick;
    logic          tick_run;
    logic          sample_en;
    logic          in_opcode;

    assign tick_run       = (state == ST_SETUP) || (state == ST_XFER) || (state == ST_GAP);
    assign sample_en      = (state == ST_XFER) && tick && !spi_sck
                            && (bit_idx >= BW'(HDR_BITS));
    assign in_opcode      = ((state == ST_SETUP) || (state == ST_XFER)) && (bit_idx < BW'(8));
    assign spi_mosi       = in_opcode ? READ_OP[~bit_idx[2:0]] : 1'b0;
    assign cpu_start_addr = LOAD_BASE;

    sbl_tick_gen #(
        .HALF_PERIOD(HALF_PERIOD)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tick_run),
        .tick (tick)
    );

    sbl_rx_assembler #(
        .RAM_AW   (RAM_AW),
        .LOAD_BASE(LOAD_BASE)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample_en),
        .bit_in   (spi_miso),
        .ram_addr (ram_addr),
        .ram_wdata(ram_wdata),
        .ram_we   (ram_we)
    );

    // Sequence the transaction: select, clock the bits, release, hand over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            spi_cs_n  <= 1'b1;
            spi_sck   <= 1'b0;
            bit_idx   <= '0;
            gap_cnt   <= 1'b0;
            boot_done <= 1'b0;
            cpu_run   <= 1'b0;
        end else begin
            cpu_run <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SETUP;
                        spi_cs_n <= 1'b0;
                        bit_idx  <= '0;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        spi_sck <= !spi_sck;
                        if (spi_sck) begin
                            if (bit_idx == BW'(TOTAL_BITS - 1)) begin
                                spi_cs_n <= 1'b1;
                                gap_cnt  <= 1'b0;
                                state    <= ST_GAP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        gap_cnt <= 1'b1;
                        if (gap_cnt) begin
                            state     <= ST_DONE;
                            boot_done <= 1'b1;
                            cpu_run   <= 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ST_DONE;
                end
            endcase
        end
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R2
    AST_NO_WRITE_IN_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && bit_idx < BW'(HDR_BITS)) |-> !ram_we); // R3
    AST_CS_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> ($past(bit_idx) == BW'(TOTAL_BITS - 1))); // R6
    AST_RUN_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> boot_done); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> (boot_done && spi_cs_n)); // R10

endmodule

// File: tb/tb_spi_boot_loader.sv
// Bench: behavioural serial-memory model with 1..4 address bytes; every
// clock is compared against expectations derived from the requirements.
module tb_spi_boot_loader;
    localparam int HP         = 2;
    localparam int RAW        = 10;
    localparam int TOTAL_BITS = 4136;
    localparam int IMG        = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b0;
    logic cs_n, sck, mosi, we, done, run;
    logic [RAW-1:0] addr, start_addr;
    logic [7:0] wdata;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit wd_fired = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    spi_boot_loader dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso),
        .ram_addr(addr), .ram_wdata(wdata), .ram_we(we),
        .boot_done(done), .cpu_run(run), .cpu_start_addr(start_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > 190000 && !wd_fired) begin
            wd_fired = 1'b1;
            check(1'b0, "watchdog", cyc, 190000);
        end
    endtask

    // Memory content: wraps at 256 bytes for a 1-byte-address part.
    function automatic logic [7:0] mem_byte(input int k, input int nab);
        int kk;
        kk = (nab == 1) ? (k % 256) : k;
        return 8'((kk * 29 + nab * 5 + (kk >> 3)) & 255);
    endfunction

    // Bit the memory drives before rising edge number rel.
    function automatic logic slave_bit(input int rel, input int nab);
        int d;
        logic [7:0] b;
        if (rel < 8 + 8 * nab) return logic'(((rel * 7) >> 2) & 1); // junk / ignored
        d = rel - 8 - 8 * nab;
        b = mem_byte(d / 8, nab);
        return b[7 - (d % 8)];
    endfunction

    task automatic run_load(input int nab, input int restart_at, input bit poke_after);
        int rises = 0, wcount = 0, cs_falls = 0, last_rise = 0, cs_rise_cyc = 0;
        logic p_sck = 1'b0, p_cs = 1'b1, p_we = 1'b0;
        bit restarted = 1'b0;
        int limit;
        rst_n = 1'b0;
        start = 1'b0;
        miso = 1'b0;
        repeat (3) step();
        check(cs_n == 1'b1 && sck == 1'b0 && we == 1'b0 && done == 1'b0 && run == 1'b0,
              "R1", {cs_n, sck, we, done, run}, 5'b10000);
        rst_n = 1'b1;
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        limit = cyc + TOTAL_BITS * 2 * HP + 200;
        while (!done && cyc < limit) begin
            step();
            start = 1'b0;
            if (cs_n && sck) check(1'b0, "R2 sck while deselected", sck, 0);
            if (run && !done) check(1'b0, "R8 run without done", run, 0);
            if (p_cs && !cs_n) begin
                cs_falls++;
                miso = slave_bit(rises, nab);
            end
            if (!p_cs && cs_n) cs_rise_cyc = cyc;
            if (!p_sck && sck) begin
                if (cs_n) check(1'b0, "R6 edge outside select", rises, 0);
                if (rises < 8)
                    check(mosi == 1'((8'h03 >> (7 - rises)) & 1), "R2 opcode bit", mosi, (8'h03 >> (7 - rises)) & 1);
                else if (rises < 40)
                    check(mosi == 1'b0, "R3 address bit", mosi, 0);
                if (rises > 0) check(cyc - last_rise == 2 * HP, "R7 sck period", cyc - last_rise, 2 * HP);
                last_rise = cyc;
                rises++;
            end
            if (p_sck && !sck) miso = slave_bit(rises, nab);
            if (we) begin
                check(!p_we, "R5 strobe width", p_we, 0);
                check(rises >= 41, "R3 write during header", rises, 41);
                check(addr == RAW'(16'h100 + wcount), "R5 address", addr, 16'h100 + wcount);
                check(wdata == mem_byte((4 - nab) + wcount, nab), "R4 data", wdata, mem_byte((4 - nab) + wcount, nab));
                wcount++;
            end
            if (rises == restart_at && !restarted) begin
                restarted = 1'b1;
                start = 1'b1; // R9: ignored mid-load
            end
            p_sck = sck;
            p_cs = cs_n;
            p_we = we;
        end
        check(done == 1'b1, "R8 done reached", done, 1);
        check(run == 1'b1, "R8 run with done", run, 1);
        check(start_addr == RAW'(16'h100), "R8 start address", start_addr, 16'h100);
        check(cs_n == 1'b1 && cyc - cs_rise_cyc >= 2 * HP, "R8 idle gap", cyc - cs_rise_cyc, 2 * HP);
        check(rises == TOTAL_BITS, "R6 edge count", rises, TOTAL_BITS);
        check(cs_falls == 1, "R6 R9 single select", cs_falls, 1);
        check(wcount == IMG, "R4 byte count", wcount, IMG);
        step();
        check(run == 1'b0 && done == 1'b1, "R8 run pulse width", {run, done}, 2'b01);
        if (poke_after) begin
            start = 1'b1;
            step();
            start = 1'b0;
            for (int i = 0; i < 60; i++) begin
                step();
                if (!cs_n || sck || we || !done)
                    check(1'b0, "R10 restart after done", {cs_n, sck, we, done}, 4'b1001);
            end
            check(cs_n && !we && done, "R10 idle after done", {cs_n, we, done}, 3'b101);
        end
    endtask

    initial begin
        run_load(4, -1, 1'b0);
        run_load(3, 100, 1'b0);
        run_load(2, 2000, 1'b0);
        run_load(1, -1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule